// File: doc/BRIEF.md
# Dual-Processor Suspend Entry Sequencer

This block is the state machine in a two-processor host bridge that takes the system from normal running into a low-power suspend and back again. A stop-clock request starts it. It then collects a Stop Grant special cycle from every processor. After that it asks for the internal queues to be emptied and drops the connect line to each processor. Once every processor has withdrawn its ready signal, it asks the DRAM controller for self-refresh. When the southbridge raises its clock-stop input, it switches off the gated internal clock trees. One tree stays running, and that tree feeds the DRAM clock outputs.

Wake-up runs in a fixed order. When clock-stop falls, the clock trees come back first. Self-refresh is released next, and the block waits for the DRAM controller to drop its acknowledge. Connect is then raised to both processors, and the block returns to full-on once every processor reports ready. During entry the processors are still connected, and any non-NOP cycle from either of them cancels the entry and sends the block straight back to full-on. A snoop probe that is still in progress holds off the disconnect until the probe completes.

Bus-cycle decoding, the DRAM controller and the clock synthesizer are outside this block. They appear only as single-bit handshake inputs.

Top module: `suspend_seq`

## Requirements
- R1: After reset, both connect outputs are high, flush_req and sr_req are low, and every tree_en bit is high.
- R2: flush_req rises only after stpclk_req has been seen and a grant_evt pulse has arrived from both processors. The two pulses may come in either order or in the same cycle. With two registers on the path, flush_req rises two cycles after the cycle of the last pulse. Grant pulses that arrive in full-on while stpclk_req is low are ignored.
- R3: flush_req stays high, with both connects still high, until queues_empty is seen. It falls on the next clock edge.
- R4: One cycle after the flush ends, both connect outputs go low, unless probe_busy is high. While probe_busy is high, connect stays high. Connect drops on the first edge at which probe_busy is low.
- R5: After disconnect, sr_req rises only on the edge after every cpu_ready bit reads low.
- R6: A busy_cycle pulse from either processor while a Stop Grant is awaited, while the flush is running, or while the disconnect is held returns the block to full-on on the next edge. Both recorded Stop Grants are discarded, so a new entry needs fresh grants from both processors.
- R7: The gated clock trees switch off only on the edge after sr_ack and clk_stop_req are both high in self-refresh. While gated, tree_en equals the inverse of GATED_MASK; with the default mask 4'b1110 this is 4'b0001, so bit 0, the DRAM clock tree, stays on.
- R8: When clk_stop_req falls, all trees turn on at the next edge while sr_req is still high. sr_req falls one edge later. The connect outputs rise on the edge after sr_ack reads low.
- R9: While the processors are being reconnected, full-on is reached only once every cpu_ready bit is high. Grant pulses seen before that point are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stpclk_req | input | 1 | Stop-clock request to the processors has been issued |
| grant_evt | input | NUM_CPU | One-cycle pulse per processor for a decoded Stop Grant special cycle |
| busy_cycle | input | NUM_CPU | One-cycle pulse per processor for a non-NOP bus cycle |
| queues_empty | input | 1 | All internal queues are drained |
| probe_busy | input | 1 | A snoop probe is in progress |
| cpu_ready | input | NUM_CPU | Ready indication from each processor |
| clk_stop_req | input | 1 | Clock-stop request from the southbridge |
| sr_ack | input | 1 | DRAM controller acknowledges self-refresh |
| cpu_connect | output | NUM_CPU | Connect line to each processor |
| flush_req | output | 1 | Request to drain the internal queues |
| sr_req | output | 1 | Self-refresh request to the DRAM controller |
| tree_en | output | NUM_TREES | Enable for each internal clock tree |

## Verification
The bench sends the Stop Grants one at a time in both orders and also both in the same cycle. A design that moves on after a single grant raises flush_req too early. A design that keeps grants from an earlier attempt does the same after a cancelled entry or after a wake-up.

A probe held across the disconnect point catches a design that drops connect under a live probe. Processors that withdraw ready one at a time catch a design that requests self-refresh too early. The bench also waits on sr_ack at the gating step and again at the reconnect step. A design that skips either handshake, or that releases self-refresh before the clocks are back, shows the wrong tree_en, sr_req or connect value in a cycle that the bench samples.

// File: rtl/susp_pkg.sv
package susp_pkg;
  localparam int ST_W = 4;
  typedef enum logic [ST_W-1:0] {
    ST_FULL_ON,
    ST_WAIT_GRANTS,
    ST_FLUSH,
    ST_DISCONNECT,
    ST_WAIT_NOT_READY,
    ST_SELF_REFRESH,
    ST_CLOCKS_GATED,
    ST_UNGATE,
    ST_SR_EXIT,
    ST_RECONNECT
  } susp_state_e;
endpackage

// File: rtl/susp_rst_sync.sv
module susp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/susp_grant_latch.sv
module susp_grant_latch #(
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               clr,
  input  logic [NUM_CPU-1:0] grant_evt,
  output logic               all_seen
);
  logic [NUM_CPU-1:0] flag_q;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    logic set_en;
    assign set_en = arm && grant_evt[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (clr)    flag_q[i] <= 1'b0;
      else if (set_en) flag_q[i] <= 1'b1;
    end

    // R2: a recorded Stop Grant persists until the block returns to full-on
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr) |=> flag_q[i]);
  end

  assign all_seen = &flag_q;
endmodule

// File: rtl/susp_clk_gate.sv
module susp_clk_gate #(
  parameter int                   NUM_TREES  = 4,
  parameter logic [NUM_TREES-1:0] GATED_MASK = 4'b1110
) (
  input  logic                 gate,
  output logic [NUM_TREES-1:0] tree_en
);
  for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
    if (GATED_MASK[t]) begin : g_gated
      assign tree_en[t] = ~gate;
    end else begin : g_kept
      assign tree_en[t] = 1'b1;
    end
  end
endmodule

// File: rtl/susp_fsm.sv
module susp_fsm
  import susp_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stpclk_req,
  input  logic               all_granted,
  input  logic [NUM_CPU-1:0] busy_cycle,
  input  logic               queues_empty,
  input  logic               probe_busy,
  input  logic [NUM_CPU-1:0] cpu_ready,
  input  logic               clk_stop_req,
  input  logic               sr_ack,
  output logic               connect_all,
  output logic               flush_req,
  output logic               sr_req,
  output logic               gate_trees,
  output logic               arm,
  output logic               clr
);
  susp_state_e st_q, st_d;
  logic        st_en;
  logic        any_busy, none_ready, all_ready, trees_on;

  assign any_busy   = |busy_cycle;
  assign none_ready = (cpu_ready == '0);
  assign all_ready  = &cpu_ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FULL_ON:        if (stpclk_req) st_d = ST_WAIT_GRANTS;
      ST_WAIT_GRANTS:    if (any_busy) st_d = ST_FULL_ON;
                         else if (all_granted) st_d = ST_FLUSH;
      ST_FLUSH:          if (any_busy) st_d = ST_FULL_ON;
                         else if (queues_empty) st_d = ST_DISCONNECT;
      ST_DISCONNECT:     if (any_busy) st_d = ST_FULL_ON;
                         else if (!probe_busy) st_d = ST_WAIT_NOT_READY;
      ST_WAIT_NOT_READY: if (none_ready) st_d = ST_SELF_REFRESH;
      ST_SELF_REFRESH:   if (sr_ack && clk_stop_req) st_d = ST_CLOCKS_GATED;
      ST_CLOCKS_GATED:   if (!clk_stop_req) st_d = ST_UNGATE;
      ST_UNGATE:         st_d = ST_SR_EXIT;
      ST_SR_EXIT:        if (!sr_ack) st_d = ST_RECONNECT;
      ST_RECONNECT:      if (all_ready) st_d = ST_FULL_ON;
      default:           st_d = ST_FULL_ON;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_FULL_ON;
    else if (st_en) st_q <= st_d;
  end

  assign connect_all = (st_q == ST_FULL_ON) || (st_q == ST_WAIT_GRANTS) ||
                       (st_q == ST_FLUSH) || (st_q == ST_DISCONNECT) ||
                       (st_q == ST_RECONNECT);
  assign flush_req   = (st_q == ST_FLUSH);
  assign sr_req      = (st_q == ST_SELF_REFRESH) || (st_q == ST_CLOCKS_GATED) ||
                       (st_q == ST_UNGATE);
  assign gate_trees  = (st_q == ST_CLOCKS_GATED);
  assign trees_on    = ~gate_trees;
  assign arm         = stpclk_req || (st_q != ST_FULL_ON);
  assign clr         = (st_d == ST_FULL_ON) && (st_q != ST_FULL_ON);

  // R2: the flush starts only after both grants are on record
  a_r2_flush_after_grants: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(all_granted));

  // R4: a live probe keeps the processors connected
  a_r4_probe_holds_connect: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISCONNECT && probe_busy && !any_busy) |=> connect_all);

  // R5: self-refresh is requested only once no processor is ready
  a_r5_sr_after_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req) |-> $past(none_ready));

  // R6: a bus cycle during entry cancels it
  a_r6_busy_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT_GRANTS || st_q == ST_FLUSH || st_q == ST_DISCONNECT) && any_busy)
      |=> (st_q == ST_FULL_ON));

  // R7: gating follows the self-refresh acknowledge and clock-stop
  a_r7_gate_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trees_on) |-> $past(sr_ack && clk_stop_req));

  // R8: the clocks return while DRAM is still in self-refresh
  a_r8_ungate_before_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trees_on) |-> sr_req);

  // R8: reconnect follows the release of the acknowledge
  a_r8_reconnect_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect_all) |-> $past(!sr_ack));
endmodule

// File: rtl/suspend_seq.sv
module suspend_seq #(
  parameter int                   NUM_CPU    = 2,
  parameter int                   NUM_TREES  = 4,
  parameter logic [NUM_TREES-1:0] GATED_MASK = 4'b1110,
  parameter int                   RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stpclk_req,
  input  logic [NUM_CPU-1:0]   grant_evt,
  input  logic [NUM_CPU-1:0]   busy_cycle,
  input  logic                 queues_empty,
  input  logic                 probe_busy,
  input  logic [NUM_CPU-1:0]   cpu_ready,
  input  logic                 clk_stop_req,
  input  logic                 sr_ack,
  output logic [NUM_CPU-1:0]   cpu_connect,
  output logic                 flush_req,
  output logic                 sr_req,
  output logic [NUM_TREES-1:0] tree_en
);
  logic rst_sync_n;
  logic all_granted, connect_all, gate_trees, arm, clr;

  susp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  susp_grant_latch #(.NUM_CPU(NUM_CPU)) u_grants (
    .clk(clk), .rst_n(rst_sync_n), .arm(arm), .clr(clr),
    .grant_evt(grant_evt), .all_seen(all_granted)
  );

  susp_fsm #(.NUM_CPU(NUM_CPU)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .stpclk_req(stpclk_req),
    .all_granted(all_granted), .busy_cycle(busy_cycle),
    .queues_empty(queues_empty), .probe_busy(probe_busy),
    .cpu_ready(cpu_ready), .clk_stop_req(clk_stop_req), .sr_ack(sr_ack),
    .connect_all(connect_all), .flush_req(flush_req), .sr_req(sr_req),
    .gate_trees(gate_trees), .arm(arm), .clr(clr)
  );

  susp_clk_gate #(.NUM_TREES(NUM_TREES), .GATED_MASK(GATED_MASK)) u_gate (
    .gate(gate_trees), .tree_en(tree_en)
  );

  assign cpu_connect = {NUM_CPU{connect_all}};
endmodule

// File: tb/suspend_seq_bench.sv
module suspend_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       stpclk_req, queues_empty, probe_busy, clk_stop_req, sr_ack;
  logic [1:0] grant_evt, busy_cycle, cpu_ready;
  logic [1:0] cpu_connect;
  logic       flush_req, sr_req;
  logic [3:0] tree_en;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  suspend_seq u_suspend_seq (
    .clk(clk), .rst_n(rst_n), .stpclk_req(stpclk_req), .grant_evt(grant_evt),
    .busy_cycle(busy_cycle), .queues_empty(queues_empty), .probe_busy(probe_busy),
    .cpu_ready(cpu_ready), .clk_stop_req(clk_stop_req), .sr_ack(sr_ack),
    .cpu_connect(cpu_connect), .flush_req(flush_req), .sr_req(sr_req),
    .tree_en(tree_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // From full-on: raise the request, pulse both grants, reach FLUSH
  task automatic enter_flush();
    stpclk_req = 1'b1; cyc(1);
    grant_evt = 2'b11; cyc(1);
    grant_evt = 2'b00; stpclk_req = 1'b0; cyc(1);
  endtask

  task automatic abort_now(input logic [1:0] who);
    busy_cycle = who; stpclk_req = 1'b0; cyc(1);
    busy_cycle = 2'b00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    stpclk_req = 0; grant_evt = 0; busy_cycle = 0; queues_empty = 0;
    probe_busy = 0; cpu_ready = 2'b11; clk_stop_req = 0; sr_ack = 0;
    cyc(3);
    chk("R1", "connect in reset", cpu_connect, 2'b11);
    rst_n = 1'b1; cyc(3);
    chk("R1", "connect", cpu_connect, 2'b11);
    chk("R1", "flush_req", flush_req, 0);
    chk("R1", "sr_req", sr_req, 0);
    chk("R1", "tree_en", tree_en, 4'b1111);
  endtask

  task automatic t_full_cycle();
    stpclk_req = 1'b1; cyc(1);
    grant_evt = 2'b01; cyc(1);
    grant_evt = 2'b00; cyc(2);
    chk("R2", "flush after one grant", flush_req, 0);
    grant_evt = 2'b10; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R2", "flush after both grants", flush_req, 1);
    stpclk_req = 1'b0; cyc(3);
    chk("R3", "flush held", flush_req, 1);
    chk("R3", "connect during flush", cpu_connect, 2'b11);
    queues_empty = 1'b1; cyc(1);
    chk("R3", "flush ends", flush_req, 0);
    chk("R4", "connect before drop", cpu_connect, 2'b11);
    cyc(1);
    chk("R4", "connect dropped", cpu_connect, 2'b00);
    queues_empty = 1'b0; cyc(3);
    chk("R5", "sr_req with ready high", sr_req, 0);
    cpu_ready = 2'b01; cyc(2);
    chk("R5", "sr_req with one ready", sr_req, 0);
    cpu_ready = 2'b00; cyc(1);
    chk("R5", "sr_req raised", sr_req, 1);
    clk_stop_req = 1'b1; cyc(3);
    chk("R7", "trees before ack", tree_en, 4'b1111);
    sr_ack = 1'b1; cyc(1);
    chk("R7", "trees gated", tree_en, 4'b0001);
    cyc(2);
    chk("R7", "trees stay gated", tree_en, 4'b0001);
    chk("R7", "sr_req while gated", sr_req, 1);
    clk_stop_req = 1'b0; cyc(1);
    chk("R8", "trees back", tree_en, 4'b1111);
    chk("R8", "sr_req still high", sr_req, 1);
    cyc(1);
    chk("R8", "sr_req released", sr_req, 0);
    cyc(2);
    chk("R8", "connect waits for ack low", cpu_connect, 2'b00);
    sr_ack = 1'b0; cyc(1);
    chk("R8", "connect raised", cpu_connect, 2'b11);
    stpclk_req = 1'b1; grant_evt = 2'b11; cyc(1);
    grant_evt = 2'b00; cyc(3);
    chk("R9", "no entry before ready", flush_req, 0);
    cpu_ready = 2'b11; cyc(4);
    chk("R9", "old grants discarded", flush_req, 0);
    grant_evt = 2'b11; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R9", "fresh grants accepted", flush_req, 1);
    abort_now(2'b01);
    chk("R6", "abort from flush", flush_req, 0);
    chk("R6", "connect after abort", cpu_connect, 2'b11);
    cyc(2);
  endtask

  task automatic t_grant_orders();
    grant_evt = 2'b11; cyc(1);
    grant_evt = 2'b00; cyc(2);
    chk("R2", "grants without request", flush_req, 0);
    stpclk_req = 1'b1; cyc(4);
    chk("R2", "early grants ignored", flush_req, 0);
    grant_evt = 2'b11; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R2", "same-cycle grants", flush_req, 1);
    abort_now(2'b10); cyc(1);
    stpclk_req = 1'b1; cyc(1);
    grant_evt = 2'b10; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R2", "reverse order first grant", flush_req, 0);
    grant_evt = 2'b01; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R2", "reverse order both grants", flush_req, 1);
    abort_now(2'b01); cyc(1);
  endtask

  task automatic t_abort_clears();
    stpclk_req = 1'b1; cyc(1);
    grant_evt = 2'b01; cyc(1);
    grant_evt = 2'b00;
    abort_now(2'b01);
    cyc(1);
    stpclk_req = 1'b1; cyc(1);
    grant_evt = 2'b10; cyc(1);
    grant_evt = 2'b00; cyc(2);
    chk("R6", "grant discarded by abort", flush_req, 0);
    grant_evt = 2'b01; cyc(1);
    grant_evt = 2'b00; cyc(1);
    chk("R6", "entry after fresh grants", flush_req, 1);
    abort_now(2'b10); cyc(1);
  endtask

  task automatic t_probe();
    enter_flush();
    probe_busy = 1'b1; queues_empty = 1'b1; cyc(1);
    queues_empty = 1'b0; cyc(3);
    chk("R4", "connect held by probe", cpu_connect, 2'b11);
    abort_now(2'b10);
    chk("R6", "abort from held disconnect", cpu_connect, 2'b11);
    cyc(2);
    chk("R6", "stays full-on", flush_req, 0);
    enter_flush();
    queues_empty = 1'b1; cyc(1);
    queues_empty = 1'b0; cyc(2);
    chk("R4", "connect still held", cpu_connect, 2'b11);
    probe_busy = 1'b0; cyc(1);
    chk("R4", "connect dropped after probe", cpu_connect, 2'b00);
    cpu_ready = 2'b00; cyc(1);
    clk_stop_req = 1'b1; sr_ack = 1'b1; cyc(1);
    chk("R7", "gated after probe path", tree_en, 4'b0001);
    clk_stop_req = 1'b0; cyc(2);
    sr_ack = 1'b0; cyc(1);
    cpu_ready = 2'b11; cyc(2);
    chk("R9", "back to full-on", cpu_connect, 2'b11);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_grant_orders();
    t_abort_clears();
    t_probe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule